// File: doc/BRIEF.md
# Microcoded Single-Bus Control Sequencer

This block is a microcoded control unit with the 32-bit datapath it steers. All transfers share one internal bus. The datapath holds a register file of general registers, a program counter, an instruction register, a memory-address latch, an ALU operand latch and an ALU result latch. A micro-sequencer steps through a read-only control store and applies one control word per clock. Each word sets the bus-drive and bus-load enables, the memory read request and the ALU function. The next micro-address comes from one of four sources: an increment, a dispatch on the instruction opcode, a jump taken only when the zero flag is set, or a return to the fetch routine.

Every instruction starts with a three-step fetch microroutine. The fetch reads memory at the program counter, advances the counter by four through the ALU and loads the instruction register. An opcode dispatch then selects one of four short microroutines: add, subtract, branch-if-zero and load-immediate. Register selection is vertically encoded. A control word names which instruction field supplies the 5-bit register number and whether the register loads from the bus or drives it. Memory reads complete in a fixed number of steps, so there is no wait handshake. A retire pulse marks the cycle in which an instruction's results become visible. A combinational read port lets the environment inspect any general register.

Top module: `ucode_bus_ctrl`

## Requirements
- R1: While reset is held, the program counter reads 0, every general register reads 0, the micro-address is 0 and retire is low. The zero flag resets to clear.
- R2: Fetch takes micro-addresses 0, 1 and 2, with the memory read request high in all three and low in every other step. The memory address is the program counter value from step 0. After step 1 the program counter equals its old value plus 4, and step 2 loads the instruction word.
- R3: The opcode is instruction bits [31:26]. The step after fetch is micro-address 3 for opcode 0, 6 for opcode 1, 9 for opcode 2 and 12 for opcode 3. Any other opcode returns straight to micro-address 0 (a no-op of 3 cycles).
- R4: Opcode 0 (add) writes the sum of register [20:16] and register [15:11], modulo 2^32, into register [25:21]. It takes 6 cycles including fetch.
- R5: Opcode 1 (subtract) writes register [20:16] minus register [15:11], modulo 2^32, into register [25:21]. It takes 6 cycles. Add and subtract set the zero flag exactly when their result is 0.
- R6: Opcode 3 (load-immediate) writes bits [15:0], zero-extended, into register [25:21]. It takes 4 cycles and leaves the zero flag unchanged.
- R7: Opcode 2 (branch-if-zero) takes 5 cycles. Its second step is micro-address 11 when the zero flag is set and 10 otherwise. When taken, the program counter becomes bits [15:0] zero-extended. Otherwise it keeps the value already advanced by 4. The program counter changes only in fetch step 1 or micro-address 11.
- R8: Retire is high for exactly the one cycle after an instruction's last step. In that cycle the micro-address is 0 and the instruction's register and program-counter results are visible.
- R9: The destination may equal a source register, because both sources are read before the write. Register 0 is an ordinary writable register.
- R10: The read port returns the current contents of the register it selects, combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd | output | 1 | Memory read request, high during fetch steps |
| mem_addr | output | 32 | Byte address from the memory-address latch |
| mem_rdata | input | 32 | Read data, valid while mem_rd is high |
| peek_idx | input | 5 | Register number for the inspection port |
| peek_val | output | 32 | Contents of the selected general register |
| pc_out | output | 32 | Current program counter |
| uaddr | output | 4 | Current micro-address |
| retire | output | 1 | One-cycle pulse after an instruction completes |

## Verification
The program mixes load-immediate, add and subtract with results that are positive, zero and negative (wrapping). This separates operand order in subtraction from the sum, and a result of zero from a nonzero one. Branch-if-zero runs once with the flag set and once with it clear. A load-immediate between a flag-setting subtract and a branch shows whether loads disturb the flag. A skipped instruction shows whether a taken branch really redirects fetch. An add whose destination is also both sources, a write to register 0 and an unknown opcode cover the aliasing and no-op paths. On every clock the bench compares the read request, the retire pulse and the micro-address against a behavioural instruction-level model.

// File: rtl/usq_pkg.sv
package usq_pkg;

    localparam int UA_W   = 4;
    localparam int OP_W   = 6;
    localparam int RN_W   = 5;
    localparam int IMM_W  = 16;
    localparam int OP_LSB = 26;
    localparam int RD_LSB = 21;
    localparam int S1_LSB = 16;
    localparam int S2_LSB = 11;

    localparam logic [OP_W-1:0] OPC_ADD = OP_W'(0);
    localparam logic [OP_W-1:0] OPC_SUB = OP_W'(1);
    localparam logic [OP_W-1:0] OPC_BRZ = OP_W'(2);
    localparam logic [OP_W-1:0] OPC_LDI = OP_W'(3);

    localparam logic [UA_W-1:0] UA_FETCH  = UA_W'(0);
    localparam logic [UA_W-1:0] UA_ADD    = UA_W'(3);
    localparam logic [UA_W-1:0] UA_SUB    = UA_W'(6);
    localparam logic [UA_W-1:0] UA_BRZ    = UA_W'(9);
    localparam logic [UA_W-1:0] UA_BRZ_NT = UA_W'(10);
    localparam logic [UA_W-1:0] UA_BRZ_T  = UA_W'(11);
    localparam logic [UA_W-1:0] UA_LDI    = UA_W'(12);

    typedef enum logic [1:0] {NX_STEP, NX_DISPATCH, NX_IFZERO, NX_REFETCH} nxt_e;
    typedef enum logic [1:0] {FN_INC4, FN_ADD, FN_SUB} alu_e;
    typedef enum logic [1:0] {RS_NONE, RS_SRC1, RS_SRC2, RS_DEST} rsel_e;

    typedef struct packed {
        logic  pc_ld;
        logic  pc_drv;
        logic  pc_maddr;
        logic  ir_drv;
        logic  ir_memld;
        logic  a_ld;
        logic  c_ld;
        logic  c_drv;
        logic  rd_req;
        rsel_e rsel;
        logic  r_ld;
        alu_e  fn;
    } ctl_t;

    typedef struct packed {
        nxt_e            nxt;
        logic [UA_W-1:0] jump;
    } seqf_t;

    typedef struct packed {
        ctl_t  ctl;
        seqf_t seq;
    } uword_t;

    function automatic logic [UA_W-1:0] route(input logic [OP_W-1:0] op);
        case (op)
            OPC_ADD: route = UA_ADD;
            OPC_SUB: route = UA_SUB;
            OPC_BRZ: route = UA_BRZ;
            OPC_LDI: route = UA_LDI;
            default: route = UA_FETCH;
        endcase
    endfunction

endpackage

// File: rtl/usq_store.sv
module usq_store
    import usq_pkg::*;
(
    input  logic [UA_W-1:0] upc,
    output uword_t          word
);

    function automatic uword_t arith_step(input int unsigned k, input alu_e f);
        uword_t w;
        w = '0;
        case (k)
            0: begin
                w.ctl.rsel = RS_SRC1;
                w.ctl.a_ld = 1'b1;
            end
            1: begin
                w.ctl.rsel = RS_SRC2;
                w.ctl.fn   = f;
                w.ctl.c_ld = 1'b1;
            end
            default: begin
                w.ctl.c_drv = 1'b1;
                w.ctl.rsel  = RS_DEST;
                w.ctl.r_ld  = 1'b1;
                w.seq.nxt   = NX_REFETCH;
            end
        endcase
        return w;
    endfunction

    always_comb begin
        word = '0;
        case (upc)
            UA_FETCH: begin
                word.ctl.pc_maddr = 1'b1;
                word.ctl.rd_req   = 1'b1;
                word.ctl.pc_drv   = 1'b1;
                word.ctl.fn       = FN_INC4;
                word.ctl.c_ld     = 1'b1;
            end
            UA_FETCH + UA_W'(1): begin
                word.ctl.rd_req = 1'b1;
                word.ctl.c_drv  = 1'b1;
                word.ctl.pc_ld  = 1'b1;
            end
            UA_FETCH + UA_W'(2): begin
                word.ctl.rd_req   = 1'b1;
                word.ctl.ir_memld = 1'b1;
                word.seq.nxt      = NX_DISPATCH;
            end
            UA_ADD:              word = arith_step(0, FN_ADD);
            UA_ADD + UA_W'(1):   word = arith_step(1, FN_ADD);
            UA_ADD + UA_W'(2):   word = arith_step(2, FN_ADD);
            UA_SUB:              word = arith_step(0, FN_SUB);
            UA_SUB + UA_W'(1):   word = arith_step(1, FN_SUB);
            UA_SUB + UA_W'(2):   word = arith_step(2, FN_SUB);
            UA_BRZ: begin
                word.seq.nxt  = NX_IFZERO;
                word.seq.jump = UA_BRZ_T;
            end
            UA_BRZ_NT: word.seq.nxt = NX_REFETCH;
            UA_BRZ_T: begin
                word.ctl.ir_drv = 1'b1;
                word.ctl.pc_ld  = 1'b1;
                word.seq.nxt    = NX_REFETCH;
            end
            UA_LDI: begin
                word.ctl.ir_drv = 1'b1;
                word.ctl.rsel   = RS_DEST;
                word.ctl.r_ld   = 1'b1;
                word.seq.nxt    = NX_REFETCH;
            end
            default: word.seq.nxt = NX_REFETCH;
        endcase
    end

endmodule

// File: rtl/usq_seq.sv
module usq_seq
    import usq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  seqf_t           seq,
    input  logic [OP_W-1:0] opcode,
    input  logic            zero,
    output logic [UA_W-1:0] upc,
    output logic            retire
);

    typedef struct packed {
        logic [UA_W-1:0] upc;
        logic            retire;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (seq.nxt)
            NX_STEP:     st_d.upc = st_q.upc + UA_W'(1);
            NX_DISPATCH: st_d.upc = route(opcode);
            NX_IFZERO:   st_d.upc = zero ? seq.jump : st_q.upc + UA_W'(1);
            default:     st_d.upc = UA_FETCH;
        endcase
        st_d.retire = (st_d.upc == UA_FETCH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign upc    = st_q.upc;
    assign retire = st_q.retire;

endmodule

// File: rtl/usq_datapath.sv
module usq_datapath
    import usq_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ctl_t            ctl,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic [RN_W-1:0] peek_idx,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] mar,
    output logic [OP_W-1:0] opcode,
    output logic            zero,
    output logic [XLEN-1:0] peek_val
);

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] gpr;
        logic [XLEN-1:0]           pc;
        logic [XLEN-1:0]           ir;
        logic [XLEN-1:0]           mar;
        logic [XLEN-1:0]           a;
        logic [XLEN-1:0]           c;
        logic                      z;
    } dp_t;

    dp_t dp_d, dp_q;

    logic [RN_W-1:0] ridx;
    logic [XLEN-1:0] bus;
    logic [XLEN-1:0] alu_y;
    logic [NREG-1:0] wr_en;

    always_comb begin
        case (ctl.rsel)
            RS_SRC1: ridx = dp_q.ir[S1_LSB +: RN_W];
            RS_SRC2: ridx = dp_q.ir[S2_LSB +: RN_W];
            default: ridx = dp_q.ir[RD_LSB +: RN_W];
        endcase
    end

    for (genvar g = 0; g < NREG; g++) begin : g_wen
        assign wr_en[g] = (ctl.rsel != RS_NONE) && ctl.r_ld && (ridx == RN_W'(g));
    end

    always_comb begin
        bus = '0;
        if (ctl.rsel != RS_NONE && !ctl.r_ld) bus = dp_q.gpr[ridx];
        if (ctl.pc_drv) bus = dp_q.pc;
        if (ctl.c_drv)  bus = dp_q.c;
        if (ctl.ir_drv) bus = {{(XLEN-IMM_W){1'b0}}, dp_q.ir[IMM_W-1:0]};
    end

    always_comb begin
        case (ctl.fn)
            FN_ADD:  alu_y = dp_q.a + bus;
            FN_SUB:  alu_y = dp_q.a - bus;
            default: alu_y = bus + XLEN'(4);
        endcase
    end

    always_comb begin
        dp_d = dp_q;
        if (ctl.pc_maddr) dp_d.mar = dp_q.pc;
        if (ctl.pc_ld)    dp_d.pc  = bus;
        if (ctl.ir_memld) dp_d.ir  = mem_rdata;
        if (ctl.a_ld)     dp_d.a   = bus;
        if (ctl.c_ld) begin
            dp_d.c = alu_y;
            if (ctl.fn != FN_INC4) dp_d.z = (alu_y == '0);
        end
        for (int i = 0; i < NREG; i++) begin
            if (wr_en[i]) dp_d.gpr[i] = bus;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign pc       = dp_q.pc;
    assign mar      = dp_q.mar;
    assign zero     = dp_q.z;
    assign opcode   = dp_d.ir[OP_LSB +: OP_W];
    assign peek_val = dp_q.gpr[peek_idx];

endmodule

// File: rtl/ucode_bus_ctrl.sv
module ucode_bus_ctrl
    import usq_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            mem_rd,
    output logic [XLEN-1:0] mem_addr,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic [RN_W-1:0] peek_idx,
    output logic [XLEN-1:0] peek_val,
    output logic [XLEN-1:0] pc_out,
    output logic [UA_W-1:0] uaddr,
    output logic            retire
);

    uword_t          word;
    logic [OP_W-1:0] opcode;
    logic            zero;

    usq_store i_store (
        .upc  (uaddr),
        .word (word)
    );

    usq_seq i_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .seq    (word.seq),
        .opcode (opcode),
        .zero   (zero),
        .upc    (uaddr),
        .retire (retire)
    );

    usq_datapath #(.XLEN(XLEN), .NREG(NREG)) i_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (word.ctl),
        .mem_rdata (mem_rdata),
        .peek_idx  (peek_idx),
        .pc        (pc_out),
        .mar       (mem_addr),
        .opcode    (opcode),
        .zero      (zero),
        .peek_val  (peek_val)
    );

    assign mem_rd = word.ctl.rd_req;

endmodule

// File: rtl/ucode_bus_ctrl_chk.sv
module ucode_bus_ctrl_chk
    import usq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_rd,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] pc_out,
    input logic [UA_W-1:0] uaddr,
    input logic            retire
);

    a_r2_read_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr <= UA_W'(2)) |-> mem_rd);

    a_r2_no_read_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr > UA_W'(2)) |-> !mem_rd);

    a_r2_addr_from_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == UA_FETCH) |=> (mem_addr == $past(pc_out)));

    a_r2_pc_plus4: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == UA_W'(1)) |=> (pc_out == $past(pc_out) + XLEN'(4)));

    a_r7_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr != UA_W'(1) && uaddr != UA_BRZ_T) |=> $stable(pc_out));

    a_r8_retire_at_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (uaddr == UA_FETCH));

    a_r8_retire_single: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire);

endmodule

bind ucode_bus_ctrl ucode_bus_ctrl_chk #(.XLEN(XLEN)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .pc_out   (pc_out),
    .uaddr    (uaddr),
    .retire   (retire)
);

// File: tb/test_ucode_bus_ctrl.sv
`timescale 1ns/1ps
module test_ucode_bus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata;
    logic [4:0]  peek_idx = '0;
    logic [31:0] peek_val;
    logic [31:0] pc_out;
    logic [3:0]  uaddr;
    logic        retire;

    int nchk = 0;
    int nfail = 0;

    logic [31:0] prog [64];
    logic [31:0] mr [32];
    logic [31:0] mpc;
    logic        mz;

    always #4 clk = ~clk;

    assign mem_rdata = mem_rd ? prog[mem_addr[7:2]] : 32'h0;

    ucode_bus_ctrl i_ucode_bus_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .peek_idx  (peek_idx),
        .peek_val  (peek_val),
        .pc_out    (pc_out),
        .uaddr     (uaddr),
        .retire    (retire)
    );

    function automatic logic [31:0] enc_r(input int op, input int rd, input int s1, input int s2);
        return {6'(op), 5'(rd), 5'(s1), 5'(s2), 11'd0};
    endfunction

    function automatic logic [31:0] enc_i(input int op, input int rd, input logic [15:0] imm);
        return {6'(op), 5'(rd), 5'd0, imm};
    endfunction

    function automatic int ilen(input logic [5:0] op);
        case (op)
            6'd0, 6'd1: return 6;
            6'd2:       return 5;
            6'd3:       return 4;
            default:    return 3;
        endcase
    endfunction

    function automatic logic [3:0] start_of(input logic [5:0] op);
        case (op)
            6'd0:    return 4'd3;
            6'd1:    return 4'd6;
            6'd2:    return 4'd9;
            6'd3:    return 4'd12;
            default: return 4'd0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic peek(input int idx, output logic [31:0] v);
        peek_idx = 5'(idx);
        #1;
        v = peek_val;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 64; i++) prog[i] = 32'h0000_0000 | {6'd62, 26'd0};
        prog[0]  = enc_i(3, 1, 16'd7);
        prog[1]  = enc_i(3, 2, 16'd5);
        prog[2]  = enc_r(0, 3, 1, 2);
        prog[3]  = enc_r(1, 4, 1, 2);
        prog[4]  = enc_r(1, 5, 2, 2);
        prog[5]  = enc_i(2, 0, 16'h0020);
        prog[6]  = enc_i(3, 6, 16'hDEAD);
        prog[7]  = {6'd63, 26'd0};
        prog[8]  = enc_r(1, 7, 2, 1);
        prog[9]  = enc_i(2, 0, 16'h0040);
        prog[10] = enc_r(0, 31, 7, 1);
        prog[11] = enc_r(0, 1, 1, 1);
        prog[12] = {6'd63, 26'd0};
        prog[13] = enc_r(0, 0, 1, 2);
        prog[14] = enc_r(1, 8, 1, 1);
        prog[15] = enc_i(3, 9, 16'hFFFF);
        prog[16] = enc_i(2, 0, 16'h0040);
        prog[17] = {6'd62, 26'd0};
        for (int i = 0; i < 32; i++) mr[i] = '0;
        mpc = '0;
        mz  = 1'b0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "pc", pc_out, 32'h0);
        chk("R1", "uaddr", 32'(uaddr), 32'h0);
        chk("R1", "retire", 32'(retire), 32'h0);
        peek(5, v);
        chk("R1", "r5", v, 32'h0);
        peek(31, v);
        chk("R10", "r31 at reset", v, 32'h0);
        rst_n = 1'b1;

        for (int k = 0; k < 20; k++) begin
            logic [31:0] inst;
            logic [5:0]  op;
            int          rd, s1, s2, n;
            logic [31:0] res;
            string       tg;
            inst = prog[mpc[7:2]];
            op   = inst[31:26];
            rd   = int'(inst[25:21]);
            s1   = int'(inst[20:16]);
            s2   = int'(inst[15:11]);
            n    = ilen(op);
            for (int s = 0; s < n; s++) begin
                if (s == 0) begin
                    chk("R8", "retire at start", 32'(retire), (k > 0) ? 32'h1 : 32'h0);
                    chk("R3", "uaddr at fetch", 32'(uaddr), 32'h0);
                end
                if (s == 3) chk("R3", "dispatch target", 32'(uaddr), 32'(start_of(op)));
                if (s == 4 && op == 6'd2) chk("R7", "branch step", 32'(uaddr), mz ? 32'd11 : 32'd10);
                if (s > 0) chk("R8", "retire mid", 32'(retire), 32'h0);
                chk("R2", "read request", 32'(mem_rd), (s < 3) ? 32'h1 : 32'h0);
                @(negedge clk);
            end
            mpc = mpc + 32'd4;
            tg  = "R3";
            case (op)
                6'd0: begin res = mr[s1] + mr[s2]; mr[rd] = res; mz = (res == 0); tg = "R4"; end
                6'd1: begin res = mr[s1] - mr[s2]; mr[rd] = res; mz = (res == 0); tg = "R5"; end
                6'd2: begin if (mz) mpc = {16'h0, inst[15:0]}; tg = "R7"; end
                6'd3: begin mr[rd] = {16'h0, inst[15:0]}; tg = "R6"; end
                default: ;
            endcase
            chk(tg, "pc after instruction", pc_out, mpc);
            if (op <= 6'd1 || op == 6'd3) begin
                peek(rd, v);
                chk(tg, "destination register", v, mr[rd]);
            end
        end
        chk("R8", "final retire", 32'(retire), 32'h1);

        // R9: aliasing destination and writable register 0
        peek(1, v);
        chk("R9", "r1 doubled in place", v, 32'd14);
        peek(0, v);
        chk("R9", "r0 written", v, 32'd19);
        // R7: taken branch skipped the load into r6
        peek(6, v);
        chk("R7", "skipped load", v, 32'h0);
        // R5: wrapped negative result
        peek(7, v);
        chk("R5", "negative difference", v, 32'hFFFF_FFFE);
        // R10: sweep all registers
        for (int i = 0; i < 32; i++) begin
            peek(i, v);
            chk("R10", "register sweep", v, mr[i]);
        end

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule